// File: doc/BRIEF.md
# Power Management Status Register Bank

This block holds the status flags that record power-management events and the enable bits that decide where those events are sent. Five hardware sources set the flags: an RTC alarm, a non-maskable wake from a management controller, a firmware release strobe, and two events from an external power-button controller (a press and a long-press override). Software reads the flags through a small register port and clears each one by writing a 1 to its position. Writing a 0 has no effect, so a flag can only go from 0 to 1 through hardware.

The block merges the flags into three outputs. The enabled flags go to the SCI output or to the SMI output, and a single select bit in the enable register picks which one. The firmware release flag always raises SCI. The wake output is driven by the enabled RTC and button flags while the system sleeps, and by the management wake flag in any power state.

The block has two active-low reset inputs. Each is asserted asynchronously and released synchronously. The hard reset clears only the enable register and stalls register writes. It leaves every status flag unchanged. The resume-well reset clears the enable register and every status flag except the override flag, which keeps its value through both resets.

Top module: `pm_status_bank`

## Requirements
- R1: After the resume-well reset is released, status bits 10, 9, 8 and 5 and the whole enable register read 0 (address 0 selects status, address 1 selects enable).
- R2: A hard reset clears the enable register and leaves every status bit at the value it held before the reset.
- R3: Status bit 11 (button override) keeps its value through both the hard reset and the resume-well reset.
- R4: A one-cycle pulse on a source sets its status bit at the next clock edge. The mapping is: RTC alarm to bit 10, management wake to bit 9, button press to bit 8, button override to bit 11, firmware release to bit 5.
- R5: Writing 1 to an implemented status bit clears it. Writing 0 leaves it unchanged.
- R6: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R7: Status bits 7:6 and every unimplemented bit read 0, and writes to them are ignored. In the enable register only bit 0 (SCI select), bit 8 (button enable) and bit 10 (RTC enable) can be written.
- R8: With enable bit 0 at 1, the OR of (bit 8 and its enable), (bit 10 and its enable) and bit 11 drives SCI. With enable bit 0 at 0, the same term drives SMI instead, and SCI does not carry it.
- R9: Status bit 5 drives SCI whatever the enables and the select bit hold.
- R10: Status bit 9 drives wake in every power state, regardless of the enables. While the sleep input is 1, enabled bits 8 and 10 also drive wake. While it is 0, they do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Hard reset, active low |
| rsm_rst_n | input | 1 | Resume-well reset, active low |
| rtc_alarm_i | input | 1 | RTC alarm event pulse |
| mgmt_wake_i | input | 1 | Non-maskable management wake pulse |
| pwrbtn_i | input | 1 | Power-button press event pulse |
| pwrbtn_ovr_i | input | 1 | Power-button override event pulse |
| fw_rls_i | input | 1 | Firmware release strobe |
| in_sleep_i | input | 1 | 1 while the system is in a sleeping state |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| sci_o | output | 1 | SCI request |
| smi_o | output | 1 | SMI request |
| wake_o | output | 1 | Wake request |

## Verification
A hardware set pulse and a software write-1-to-clear can reach the status register in the same cycle. The bench provokes this by driving the RTC alarm pulse and a status write in one cycle. That write carries a 1 both at bit 10, which is being set, and at bit 9, which is not. The outcome is judged by reading back bit 10 still set and bit 9 cleared. The behavioural model, updated each clock, must agree with every readback and every routed output on every cycle.

// File: rtl/pm_status_pkg.sv
package pm_status_pkg;
  localparam int STS_W       = 16;
  localparam int OVR_BIT     = 11;
  localparam int RTC_BIT     = 10;
  localparam int MGMT_BIT    = 9;
  localparam int BTN_BIT     = 8;
  localparam int GBL_BIT     = 5;
  localparam int SCI_SEL_BIT = 0;

  // status bits that exist in hardware
  localparam logic [STS_W-1:0] IMPL_MASK = (STS_W'(1) << OVR_BIT) | (STS_W'(1) << RTC_BIT) |
                                           (STS_W'(1) << MGMT_BIT) | (STS_W'(1) << BTN_BIT) |
                                           (STS_W'(1) << GBL_BIT);
  // status bits that ignore the resume-well reset
  localparam logic [STS_W-1:0] KEEP_MASK = STS_W'(1) << OVR_BIT;
  // writable enable bits
  localparam logic [STS_W-1:0] EN_MASK   = (STS_W'(1) << RTC_BIT) | (STS_W'(1) << BTN_BIT) |
                                           (STS_W'(1) << SCI_SEL_BIT);

  typedef enum logic {SEL_STS = 1'b0, SEL_EN = 1'b1} reg_sel_e;

  localparam int NUM_RST = 3;
  typedef enum int {RST_RSM = 0, RST_HARD = 1, RST_EN = 2} rst_idx_e;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pm_sts_cell.sv
module pm_sts_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  // a set in the same cycle as a clear wins
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i | (q_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/pm_route.sv
module pm_route
  import pm_status_pkg::*;
(
  input  logic [STS_W-1:0] sts_i,
  input  logic [STS_W-1:0] en_i,
  input  logic             in_sleep_i,
  output logic             sci_o,
  output logic             smi_o,
  output logic             wake_o
);
  logic maskable_wake;
  logic host_evt;

  always_comb begin
    maskable_wake = (sts_i[BTN_BIT] & en_i[BTN_BIT]) | (sts_i[RTC_BIT] & en_i[RTC_BIT]);
    host_evt      = maskable_wake | sts_i[OVR_BIT];
    sci_o         = (host_evt & en_i[SCI_SEL_BIT]) | sts_i[GBL_BIT];
    smi_o         = host_evt & ~en_i[SCI_SEL_BIT];
    wake_o        = (maskable_wake & in_sleep_i) | sts_i[MGMT_BIT];
  end
endmodule

// File: rtl/pm_status_bank.sv
module pm_status_bank
  import pm_status_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             hard_rst_n,
  input  logic             rsm_rst_n,
  input  logic             rtc_alarm_i,
  input  logic             mgmt_wake_i,
  input  logic             pwrbtn_i,
  input  logic             pwrbtn_ovr_i,
  input  logic             fw_rls_i,
  input  logic             in_sleep_i,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [STS_W-1:0] reg_wdata_i,
  output logic [STS_W-1:0] reg_rdata_o,
  output logic             sci_o,
  output logic             smi_o,
  output logic             wake_o
);
  logic [NUM_RST-1:0] rst_raw_n;
  logic [NUM_RST-1:0] rst_sync_n;
  logic               rsm_sync_n;
  logic               hard_sync_n;
  logic               en_sync_n;

  assign rst_raw_n[RST_RSM]  = rsm_rst_n;
  assign rst_raw_n[RST_HARD] = hard_rst_n;
  assign rst_raw_n[RST_EN]   = hard_rst_n & rsm_rst_n;

  for (genvar r = 0; r < NUM_RST; r++) begin : g_rst
    pm_rst_sync #(.STAGES(RST_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (rst_raw_n[r]),
      .srst_n (rst_sync_n[r])
    );
  end

  assign rsm_sync_n  = rst_sync_n[RST_RSM];
  assign hard_sync_n = rst_sync_n[RST_HARD];
  assign en_sync_n   = rst_sync_n[RST_EN];

  // register port decode
  logic             wr_sts;
  logic             wr_en;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;

  always_comb begin
    wr_sts  = reg_wr_i & (reg_addr_i == SEL_STS) & hard_sync_n;
    wr_en   = reg_wr_i & (reg_addr_i == SEL_EN);
    clr_vec = {STS_W{wr_sts}} & reg_wdata_i & IMPL_MASK;
    set_vec = '0;
    set_vec[OVR_BIT]  = pwrbtn_ovr_i;
    set_vec[RTC_BIT]  = rtc_alarm_i;
    set_vec[MGMT_BIT] = mgmt_wake_i;
    set_vec[BTN_BIT]  = pwrbtn_i;
    set_vec[GBL_BIT]  = fw_rls_i;
  end

  // status bits, one cell per implemented position
  logic [STS_W-1:0] sts_q;

  for (genvar b = 0; b < STS_W; b++) begin : g_sts
    if (IMPL_MASK[b]) begin : g_impl
      logic cell_rst_n;
      if (KEEP_MASK[b]) begin : g_keep
        assign cell_rst_n = 1'b1;
      end else begin : g_rsm
        assign cell_rst_n = rsm_sync_n;
      end
      pm_sts_cell u_cell (
        .clk   (clk),
        .rst_n (cell_rst_n),
        .set_i (set_vec[b]),
        .clr_i (clr_vec[b]),
        .q_o   (sts_q[b])
      );
    end else begin : g_rsvd
      assign sts_q[b] = 1'b0;
    end
  end

  // enable register
  logic [STS_W-1:0] en_q;
  logic [STS_W-1:0] en_d;

  always_comb en_d = reg_wdata_i & EN_MASK;

  always_ff @(posedge clk or negedge en_sync_n) begin
    if (!en_sync_n)  en_q <= '0;
    else if (wr_en)  en_q <= en_d;
  end

  always_comb reg_rdata_o = (reg_addr_i == SEL_EN) ? en_q : sts_q;

  pm_route u_route (
    .sts_i      (sts_q),
    .en_i       (en_q),
    .in_sleep_i (in_sleep_i),
    .sci_o      (sci_o),
    .smi_o      (smi_o),
    .wake_o     (wake_o)
  );
endmodule

// File: rtl/pm_status_bank_chk.sv
module pm_status_bank_chk
  import pm_status_pkg::*;
(
  input logic             clk,
  input logic             rsm_sync_n,
  input logic             hard_sync_n,
  input logic             rtc_alarm_i,
  input logic             mgmt_wake_i,
  input logic             pwrbtn_i,
  input logic             pwrbtn_ovr_i,
  input logic             fw_rls_i,
  input logic             reg_wr_i,
  input logic             reg_addr_i,
  input logic [STS_W-1:0] reg_wdata_i,
  input logic [STS_W-1:0] reg_rdata_o,
  input logic [STS_W-1:0] sts_q,
  input logic [STS_W-1:0] en_q,
  input logic             sci_o,
  input logic             smi_o,
  input logic             wake_o
);
  logic any_evt;
  assign any_evt = rtc_alarm_i | mgmt_wake_i | pwrbtn_i | pwrbtn_ovr_i | fw_rls_i;

  // R4
  rtc_set_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    rtc_alarm_i |=> sts_q[RTC_BIT]);

  // R5
  mgmt_clr_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    (reg_wr_i && !reg_addr_i && reg_wdata_i[MGMT_BIT] && hard_sync_n && !mgmt_wake_i)
    |=> !sts_q[MGMT_BIT]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    (mgmt_wake_i && reg_wr_i && !reg_addr_i && reg_wdata_i[MGMT_BIT]) |=> sts_q[MGMT_BIT]);

  // R2
  hard_hold_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    (!hard_sync_n && !any_evt) |=> (sts_q == $past(sts_q)));

  // R7
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    !reg_addr_i |-> (reg_rdata_o[7:6] == 2'b00));

  // R8
  smi_sel_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    smi_o |-> !en_q[SCI_SEL_BIT]);

  // R9
  gbl_sci_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    sts_q[GBL_BIT] |-> sci_o);

  // R10
  mgmt_wake_chk: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    sts_q[MGMT_BIT] |-> wake_o);
endmodule

bind pm_status_bank pm_status_bank_chk i_chk (.*);

// File: tb/test_pm_status_bank.sv
module test_pm_status_bank;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        hard_rst_n, rsm_rst_n;
  logic        rtc_alarm_i, mgmt_wake_i, pwrbtn_i, pwrbtn_ovr_i, fw_rls_i;
  logic        in_sleep_i, reg_wr_i, reg_addr_i;
  logic [15:0] reg_wdata_i, reg_rdata_o;
  logic        sci_o, smi_o, wake_o;

  always #2 clk = ~clk;

  pm_status_bank i_pm_status_bank (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  logic [15:0] m_sts, m_en;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rsm_rst_n or negedge hard_rst_n) begin
    if (!rsm_rst_n) begin
      m_sts = m_sts & 16'h0800;
      m_en  = 16'h0000;
    end else if (!hard_rst_n) begin
      m_en = 16'h0000;
    end else begin
      if (reg_wr_i && !reg_addr_i) m_sts = m_sts & ~(reg_wdata_i & 16'h0F20);
      if (reg_wr_i && reg_addr_i)  m_en  = reg_wdata_i & 16'h0501;
      if (rtc_alarm_i)  m_sts[10] = 1'b1;
      if (mgmt_wake_i)  m_sts[9]  = 1'b1;
      if (pwrbtn_i)     m_sts[8]  = 1'b1;
      if (pwrbtn_ovr_i) m_sts[11] = 1'b1;
      if (fw_rls_i)     m_sts[5]  = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      logic wk, ev;
      wk = (m_sts[8] && m_en[8]) || (m_sts[10] && m_en[10]);
      ev = wk || m_sts[11];
      chk("R5 readback", reg_rdata_o, reg_addr_i ? m_en : m_sts);
      chk("R8 sci", {15'b0, sci_o}, {15'b0, (ev && m_en[0]) || m_sts[5]});
      chk("R8 smi", {15'b0, smi_o}, {15'b0, ev && !m_en[0]});
      chk("R10 wake", {15'b0, wake_o}, {15'b0, (wk && in_sleep_i) || m_sts[9]});
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    step();
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  // order: ovr, rtc, mgmt, btn, rls
  task automatic ev(input logic [4:0] m);
    step();
    {pwrbtn_ovr_i, rtc_alarm_i, mgmt_wake_i, pwrbtn_i, fw_rls_i} = m;
    step();
    {pwrbtn_ovr_i, rtc_alarm_i, mgmt_wake_i, pwrbtn_i, fw_rls_i} = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    reg_addr_i = a;
    #0.2;
    v = reg_rdata_o;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    {hard_rst_n, rsm_rst_n} = 2'b00;
    {pwrbtn_ovr_i, rtc_alarm_i, mgmt_wake_i, pwrbtn_i, fw_rls_i} = '0;
    in_sleep_i = 1'b0; reg_wr_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = '0;
    repeat (3) step();
    {hard_rst_n, rsm_rst_n} = 2'b11;
    repeat (4) step();
    wr(1'b0, 16'hFFFF);          // settle override bit
    step();
    cmp_on = 1'b1;

    rd(1'b0, v); chk("R1 status after reset", v, 16'h0000);
    rd(1'b1, v); chk("R1 enable after reset", v, 16'h0000);

    ev(5'b01000); rd(1'b0, v); chk("R4 rtc sets bit 10", v, 16'h0400);
    ev(5'b00100); rd(1'b0, v); chk("R4 mgmt sets bit 9", v, 16'h0600);
    chk("R10 mgmt wakes while awake", {15'b0, wake_o}, 16'h0001);
    ev(5'b00010); ev(5'b10000); ev(5'b00001);
    rd(1'b0, v); chk("R4 button, override, release", v, 16'h0F20);
    chk("R9 release drives sci with enables off", {15'b0, sci_o}, 16'h0001);
    chk("R8 override routed to smi", {15'b0, smi_o}, 16'h0001);

    wr(1'b0, 16'h0000); rd(1'b0, v); chk("R5 write 0 keeps bits", v, 16'h0F20);
    wr(1'b0, 16'h0400); rd(1'b0, v); chk("R5 write 1 clears bit 10", v, 16'h0B20);

    // set and clear in the same cycle
    step();
    reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_wdata_i = 16'h0600; rtc_alarm_i = 1'b1;
    step();
    reg_wr_i = 1'b0; reg_wdata_i = '0; rtc_alarm_i = 1'b0;
    rd(1'b0, v); chk("R6 set beats clear, other bit cleared", v, 16'h0D20);

    wr(1'b0, 16'h00C0); rd(1'b0, v); chk("R7 reserved status bits", v, 16'h0D20);
    wr(1'b1, 16'hFFFF); rd(1'b1, v); chk("R7 enable write mask", v, 16'h0501);

    chk("R8 sci select routes override to sci", {15'b0, sci_o, smi_o}, 16'h0002);
    wr(1'b0, 16'h0820); rd(1'b0, v); chk("R5 clear bits 11 and 5", v, 16'h0500);
    chk("R8 enabled bits drive sci", {15'b0, sci_o, smi_o}, 16'h0002);
    wr(1'b1, 16'h0500);
    chk("R8 select clear moves to smi", {15'b0, sci_o, smi_o}, 16'h0001);

    chk("R10 awake no maskable wake", {15'b0, wake_o}, 16'h0000);
    step(); in_sleep_i = 1'b1; #0.2;
    chk("R10 sleeping enabled wake", {15'b0, wake_o}, 16'h0001);
    wr(1'b1, 16'h0000);
    chk("R10 sleeping enables off", {15'b0, wake_o}, 16'h0000);
    ev(5'b00100);
    chk("R10 mgmt wake ignores enables", {15'b0, wake_o}, 16'h0001);

    wr(1'b1, 16'h0501); ev(5'b10000);
    step(); hard_rst_n = 1'b0;
    repeat (3) step();
    hard_rst_n = 1'b1;
    repeat (4) step();
    rd(1'b0, v); chk("R2 status kept through hard reset", v, 16'h0F00);
    rd(1'b1, v); chk("R2 enable cleared by hard reset", v, 16'h0000);

    step(); rsm_rst_n = 1'b0;
    repeat (3) step();
    rsm_rst_n = 1'b1;
    repeat (4) step();
    rd(1'b0, v); chk("R3 override kept, R1 others cleared", v, 16'h0800);
    rd(1'b1, v); chk("R1 enable cleared by resume reset", v, 16'h0000);

    step();
    summary();
  end
endmodule